// File: doc/BRIEF.md
# AHB Initiator-Side Region Decoder with Boot Remap

This block sits on one initiator's path into an AHB-Lite fabric. For each address phase it turns the upper address bits and a remap control into a one-hot select across seven targets: boot ROM, code RAM, data RAM, system IO, expansion IO and two DMA buffers. When the bus accepts the transfer (HREADY high), the select is copied into a data-phase register. That register then steers read data, ready and response from the chosen target back to the initiator.

The address map has three irregular features. The boot ROM is aliased in two places. System IO and expansion IO each answer in two separate windows. The bottom 256 MB can be switched from ROM to code RAM with the remap input. A parameter selects the map flavour:
- The processor flavour honours remap and decodes a narrow system window at the top of the map.
- The DMA flavour always places code RAM at zero and leaves the top window unmapped.

An address that falls in no window goes to a built-in default responder. That responder rejects real transfers with the standard two-cycle error.

Top module: `ahb_region_decoder`

## Requirements
- R1: Processor map with `remap` low: addresses 0x00000000–0x0FFFFFFF assert `hsel` bit 0 (boot ROM). 0x10000000–0x1FFFFFFF asserts bit 0 in every map and remap state.
- R2: Processor map with `remap` high: 0x00000000–0x0FFFFFFF asserts `hsel` bit 1 (code RAM). 0x20000000–0x2FFFFFFF asserts bit 1 in every map and remap state.
- R3: 0x30000000–0x3FFFFFFF asserts `hsel` bit 2 (data RAM). 0x80000000–0x8FFFFFFF asserts bit 5 (DMA buffer 1). 0x90000000–0x9FFFFFFF asserts bit 6 (DMA buffer 2).
- R4: `hsel` bit 3 (system IO) is asserted for 0x40000000–0x5FFFFFFF. In the processor map only, it is also asserted for 0xF0000000–0xF003FFFF.
- R5: `hsel` bit 4 (expansion IO) is asserted for 0x60000000–0x7FFFFFFF and for 0xA0000000–0xDFFFFFFF.
- R6: In the DMA map, 0x00000000–0x0FFFFFFF asserts `hsel` bit 1 whatever the value of `remap`. Every address at or above 0xF0000000 is unmapped.
- R7: Every other address leaves `hsel` all zero and routes to the default responder. `hsel` never has more than one bit set.
- R8: A NONSEQ (`htrans`=2) or SEQ (3) transfer accepted to the default responder is answered in its data phase as follows. First cycle: `hreadyout`=0, `hresp`=1. Second cycle: `hreadyout`=1, `hresp`=1. `hrdata` is 0 throughout.
- R9: An IDLE (0) or BUSY (1) transfer accepted to the default responder gets `hreadyout`=1 and `hresp`=0 in the following cycle.
- R10: `hrdata`, `hreadyout` and `hresp` follow the target selected in the last address phase accepted with `hready` high. While `hready` is low, that routing holds even if `haddr` changes.
- R11: Changing `remap` after an address phase has been accepted does not redirect the data phase of that transfer.
- R12: After reset, with no transfer accepted yet, `hreadyout`=1, `hresp`=0 and `hrdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type (0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ) |
| hready | input | 1 | Bus ready; an address phase is accepted when high |
| remap | input | 1 | Places code RAM at address zero (processor map) |
| hsel | output | 7 | One-hot address-phase target select |
| t_hrdata | input | 7*DATA_W | Read data from each target, target i in slice i |
| t_hreadyout | input | 7 | Ready from each target |
| t_hresp | input | 7 | Error response from each target |
| hrdata | output | DATA_W | Read data routed to the initiator |
| hreadyout | output | 1 | Ready routed to the initiator |
| hresp | output | 1 | Response routed to the initiator |

## Verification
The decode is swept over all sixteen 256 MB slices. In each slice it is probed at the slice base, at the slice top, and on both sides of the 256 KB boundary of the top window. Every probe is applied with both remap values to a processor-map instance and a DMA-map instance. This separates aliased, split and remapped windows from unmapped gaps.

Data-phase tests target the default responder with each of the four transfer types, so the error sequence is distinguished from the zero-wait reply. Two further tests stall a real target while the address or the remap input changes underneath. These show whether the response stays with the target that was accepted.

// File: rtl/ahbdec_pkg.sv
// Shared constants and types for the AHB region decoder.
// Assumes a 32-bit address map carved into 256 MB slices, plus one
// narrow window at the top that is matched on address bits [31:18].
package ahbdec_pkg;

    localparam int ADDR_W    = 32;
    localparam int N_TGT     = 7;
    localparam int DEF_IDX   = N_TGT;        // default responder slot
    localparam int N_SEL     = N_TGT + 1;
    localparam int SLICE_LSB = 28;           // 256 MB slice granularity
    localparam int WIN_LSB   = 18;           // 256 KB top window granularity

    // Bits [31:18] of 0xF0000000: the top system window.
    localparam logic [ADDR_W-WIN_LSB-1:0] SYS_TOP_TAG = 14'h3C00;

    // Bit position of each target in the one-hot select.
    typedef enum logic [2:0] {
        TGT_ROM  = 3'd0,
        TGT_CODE = 3'd1,
        TGT_DATA = 3'd2,
        TGT_SYS  = 3'd3,
        TGT_EXP  = 3'd4,
        TGT_BUF1 = 3'd5,
        TGT_BUF2 = 3'd6
    } tgt_e;

    // Default responder data-phase state.
    typedef enum logic [1:0] {
        ERR_IDLE  = 2'd0,
        ERR_FIRST = 2'd1,
        ERR_LAST  = 2'd2
    } err_st_e;

endpackage

// File: rtl/ahbdec_map.sv
// Combinational address map for one initiator.
// Takes address bits [31:18] and the remap control and produces a
// one-hot target select, or all zero for an unmapped address.
// DMA_MAP picks the variant: 0 is the processor map (remap honoured,
// top system window decoded); 1 is the DMA map (code RAM fixed at
// zero, top window unmapped).
module ahbdec_map
    import ahbdec_pkg::*;
#(
    parameter bit DMA_MAP = 1'b0
) (
    input  logic [ADDR_W-1:WIN_LSB] addr_hi,
    input  logic                    remap,
    output logic [N_TGT-1:0]        sel
);

    logic [ADDR_W-SLICE_LSB-1:0] slice;
    logic                        low_is_code;
    logic                        top_sys_hit;

    assign slice = addr_hi[ADDR_W-1:SLICE_LSB];

    generate
        if (DMA_MAP) begin : g_dma_flavour
            logic unused_dma;
            assign unused_dma  = remap ^ (^addr_hi[SLICE_LSB-1:WIN_LSB]);
            assign low_is_code = 1'b1;
            assign top_sys_hit = 1'b0;
        end else begin : g_cpu_flavour
            assign low_is_code = remap;
            assign top_sys_hit = (addr_hi == SYS_TOP_TAG);
        end
    endgenerate

    // Slice decode: one select bit per recognised window.
    always_comb begin
        sel = '0;
        unique case (slice)
            4'h0:                      sel[low_is_code ? TGT_CODE : TGT_ROM] = 1'b1;
            4'h1:                      sel[TGT_ROM]  = 1'b1;
            4'h2:                      sel[TGT_CODE] = 1'b1;
            4'h3:                      sel[TGT_DATA] = 1'b1;
            4'h4, 4'h5:                sel[TGT_SYS]  = 1'b1;
            4'h6, 4'h7:                sel[TGT_EXP]  = 1'b1;
            4'h8:                      sel[TGT_BUF1] = 1'b1;
            4'h9:                      sel[TGT_BUF2] = 1'b1;
            4'hA, 4'hB, 4'hC, 4'hD:    sel[TGT_EXP]  = 1'b1;
            4'hF:                      sel[TGT_SYS]  = top_sys_hit;
            default:                   sel = '0;
        endcase
    end

endmodule

// File: rtl/ahbdec_err_resp.sv
// Default responder for unmapped addresses.
// An accepted NONSEQ/SEQ transfer gets a two-cycle ERROR reply
// (ready low, then ready high, with resp high in both cycles).
// IDLE/BUSY transfers get a zero-wait OKAY.
// Assumes that hready is low in the first error cycle, because this
// block is then the data-phase target.
module ahbdec_err_resp
    import ahbdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hready,
    input  logic selected,     // default slot chosen this address phase
    input  logic xfer,         // htrans is NONSEQ or SEQ
    output logic readyout,
    output logic resp
);

    err_st_e st_q;

    // Advance through the error sequence, or start it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ERR_IDLE;
        end else if (st_q == ERR_FIRST) begin
            st_q <= ERR_LAST;
        end else if (hready) begin
            st_q <= (selected && xfer) ? ERR_FIRST : ERR_IDLE;
        end
    end

    // Response outputs follow the state directly.
    always_comb begin
        readyout = (st_q != ERR_FIRST);
        resp     = (st_q != ERR_IDLE);
    end

endmodule

// File: rtl/ahbdec_route.sv
// Data-phase select register and response multiplexer.
// Captures the address-phase one-hot select whenever hready is high,
// and holds it otherwise. The held select chooses which slot's data,
// ready and response reach the initiator. After reset the register
// points at the default slot (the top slot).
module ahbdec_route
    import ahbdec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hready,
    input  logic [N_SEL-1:0]        sel_a,
    input  logic [N_SEL*DATA_W-1:0] s_rdata,
    input  logic [N_SEL-1:0]        s_ready,
    input  logic [N_SEL-1:0]        s_resp,
    output logic [N_SEL-1:0]        dsel_q,
    output logic [DATA_W-1:0]       rdata,
    output logic                    ready,
    output logic                    resp
);

    localparam logic [N_SEL-1:0] DSEL_RST = {1'b1, {N_TGT{1'b0}}};

    // Capture the select on each accepted address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsel_q <= DSEL_RST;
        end else if (hready) begin
            dsel_q <= sel_a;
        end
    end

    // AND-OR multiplexer over the slots, driven by the held select.
    always_comb begin
        rdata = '0;
        ready = 1'b0;
        resp  = 1'b0;
        for (int i = 0; i < N_SEL; i++) begin
            rdata = rdata | ({DATA_W{dsel_q[i]}} & s_rdata[i*DATA_W +: DATA_W]);
            ready = ready | (dsel_q[i] & s_ready[i]);
            resp  = resp  | (dsel_q[i] & s_resp[i]);
        end
    end

endmodule

// File: rtl/ahb_region_decoder.sv
// Initiator-side AHB-Lite region decoder with boot remap.
// Decodes the address phase to a one-hot select over seven targets,
// sends unmapped addresses to a built-in error responder, and routes
// the data-phase response from the target that was accepted.
// Assumes one initiator path; arbitration lies outside this block.
module ahb_region_decoder
    import ahbdec_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit DMA_MAP = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       haddr,
    input  logic [1:0]              htrans,
    input  logic                    hready,
    input  logic                    remap,
    output logic [N_TGT-1:0]        hsel,
    input  logic [N_TGT*DATA_W-1:0] t_hrdata,
    input  logic [N_TGT-1:0]        t_hreadyout,
    input  logic [N_TGT-1:0]        t_hresp,
    output logic [DATA_W-1:0]       hrdata,
    output logic                    hreadyout,
    output logic                    hresp
);

    logic             def_sel;
    logic             def_ready;
    logic             def_resp;
    logic [N_SEL-1:0] dsel_q;
    logic             unused_low;

    assign unused_low = (^haddr[WIN_LSB-1:0]) ^ htrans[0];

    ahbdec_map #(.DMA_MAP(DMA_MAP)) u_map (
        .addr_hi (haddr[ADDR_W-1:WIN_LSB]),
        .remap   (remap),
        .sel     (hsel)
    );

    // Default slot is taken when no window matches.
    assign def_sel = ~|hsel;

    ahbdec_err_resp u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .hready   (hready),
        .selected (def_sel),
        .xfer     (htrans[1]),
        .readyout (def_ready),
        .resp     (def_resp)
    );

    ahbdec_route #(.DATA_W(DATA_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .hready  (hready),
        .sel_a   ({def_sel, hsel}),
        .s_rdata ({{DATA_W{1'b0}}, t_hrdata}),
        .s_ready ({def_ready, t_hreadyout}),
        .s_resp  ({def_resp, t_hresp}),
        .dsel_q  (dsel_q),
        .rdata   (hrdata),
        .ready   (hreadyout),
        .resp    (hresp)
    );

endmodule

// File: rtl/ahbdec_checker.sv
// Protocol checks for ahb_region_decoder, attached through bind.
// Observes the ports and the held data-phase select.
module ahbdec_checker
    import ahbdec_pkg::*;
#(
    parameter bit DMA_MAP = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       addr_top,
    input logic             xfer,
    input logic             hready,
    input logic [N_TGT-1:0] hsel,
    input logic             hreadyout,
    input logic             hresp,
    input logic [N_SEL-1:0] dsel_q
);

    // R7: at most one target selected.
    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hsel));

    // R8: accepted real transfer to default -> first error cycle.
    assert_err_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && xfer && hsel == '0) |=> (!hreadyout && hresp));

    // R8: first error cycle is followed by the completing error cycle.
    assert_err_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hreadyout && hresp) |=> (hreadyout && hresp));

    // R9: accepted IDLE/BUSY to default -> zero-wait OKAY.
    assert_idle_okay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !xfer && hsel == '0) |=> (hreadyout && !hresp));

    // R10: held routing does not move while the bus is stalled.
    assert_route_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(dsel_q));

    // R12: first cycle after reset is a ready OKAY.
    assert_reset_okay_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (hreadyout && !hresp));

    generate
        if (DMA_MAP) begin : g_dma_chk
            // R6: bottom slice always code RAM in the DMA map.
            assert_dma_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_top == 4'h0) |-> (hsel == 7'b0000010));
        end else begin : g_cpu_chk
            // R1: ROM alias slice always selects ROM.
            assert_rom_alias_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_top == 4'h1) |-> (hsel == 7'b0000001));
        end
    endgenerate

endmodule

bind ahb_region_decoder ahbdec_checker #(.DMA_MAP(DMA_MAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_top  (haddr[31:28]),
    .xfer      (htrans[1]),
    .hready    (hready),
    .hsel      (hsel),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .dsel_q    (dsel_q)
);

// File: tb/ahb_region_decoder_test.sv
// Self-checking bench: decode sweep on both map flavours, then
// data-phase scenarios on the processor-map instance.
module ahb_region_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NT = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     haddr = '0;
    logic [1:0]      htrans = 2'd0;
    logic            remap = 1'b0;
    logic [NT*DW-1:0] t_hrdata;
    logic [NT-1:0]   t_hreadyout = '1;
    logic [NT-1:0]   t_hresp = '0;

    logic [NT-1:0]   hsel_c, hsel_d;
    logic [DW-1:0]   hrdata_c, hrdata_d;
    logic            hrdy_c, hrdy_d, hresp_c, hresp_d;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NT; g++) begin : g_tdata
        assign t_hrdata[g*DW +: DW] = 32'hD000_0000 + g;
    end

    ahb_region_decoder #(.DATA_W(DW), .DMA_MAP(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans),
        .hready(hrdy_c), .remap(remap), .hsel(hsel_c),
        .t_hrdata(t_hrdata), .t_hreadyout(t_hreadyout), .t_hresp(t_hresp),
        .hrdata(hrdata_c), .hreadyout(hrdy_c), .hresp(hresp_c)
    );

    ahb_region_decoder #(.DATA_W(DW), .DMA_MAP(1'b1)) uut_dma (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans),
        .hready(hrdy_d), .remap(remap), .hsel(hsel_d),
        .t_hrdata(t_hrdata), .t_hreadyout(t_hreadyout), .t_hresp(t_hresp),
        .hrdata(hrdata_d), .hreadyout(hrdy_d), .hresp(hresp_d)
    );

    // Expected one-hot select from the address ranges in the requirements.
    function automatic logic [NT-1:0] exp_sel(logic [31:0] a, logic rm, bit dma);
        int idx = -1;
        if (a < 32'h1000_0000)      idx = (dma || rm) ? 1 : 0;
        else if (a < 32'h2000_0000) idx = 0;
        else if (a < 32'h3000_0000) idx = 1;
        else if (a < 32'h4000_0000) idx = 2;
        else if (a < 32'h6000_0000) idx = 3;
        else if (a < 32'h8000_0000) idx = 4;
        else if (a < 32'h9000_0000) idx = 5;
        else if (a < 32'hA000_0000) idx = 6;
        else if (a < 32'hE000_0000) idx = 4;
        else if (!dma && a >= 32'hF000_0000 && a <= 32'hF003_FFFF) idx = 3;
        return (idx < 0) ? '0 : NT'(1 << idx);
    endfunction

    // Requirement tag for a decode probe.
    function automatic string tag_of(logic [31:0] a, logic rm, bit dma);
        logic [3:0] s = a[31:28];
        if (dma && (s == 4'h0 || s == 4'hF)) return "R6";
        if (s == 4'h0) return rm ? "R2" : "R1";
        if (s == 4'h1) return "R1";
        if (s == 4'h2) return "R2";
        if (s == 4'h3 || s == 4'h8 || s == 4'h9) return "R3";
        if (s == 4'h4 || s == 4'h5) return "R4";
        if (s == 4'hF && exp_sel(a, rm, dma) != '0) return "R4";
        if (s == 4'hE || s == 4'hF) return "R7";
        return "R5";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    // One data-phase observation on the processor instance.
    task automatic chk_dp(string req, logic [31:0] d, logic r, logic e);
        chk(req, hrdata_c, d);
        chk(req, {31'd0, hrdy_c}, {31'd0, r});
        chk(req, {31'd0, hresp_c}, {31'd0, e});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R12: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_dp("R12", 32'd0, 1'b1, 1'b0);

        // Decode sweep: R1..R7 on both flavours.
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 5; k++) begin
                for (int rm = 0; rm < 2; rm++) begin
                    logic [31:0] off;
                    logic [31:0] a;
                    case (k)
                        0: off = 32'h0000_0000;
                        1: off = 32'h0003_FFFF;
                        2: off = 32'h0004_0000;
                        3: off = 32'h0765_4320;
                        default: off = 32'h0FFF_FFFF;
                    endcase
                    a = {s[3:0], 28'd0} | off;
                    @(negedge clk);
                    haddr = a;
                    remap = rm[0];
                    #1;
                    chk(tag_of(a, rm[0], 1'b0), {25'd0, hsel_c}, {25'd0, exp_sel(a, rm[0], 1'b0)});
                    chk(tag_of(a, rm[0], 1'b1), {25'd0, hsel_d}, {25'd0, exp_sel(a, rm[0], 1'b1)});
                    chk("R7", {31'd0, ($countones(hsel_c) > 1)}, 32'd0);
                end
            end
        end

        // R9: IDLE and BUSY to the default responder.
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            haddr = 32'hE000_0000; htrans = t[1:0]; remap = 1'b0;
            step();
            chk_dp("R9", 32'd0, 1'b1, 1'b0);
        end

        // R8: NONSEQ to an unmapped slice, SEQ just past the top window.
        for (int t = 2; t < 4; t++) begin
            @(negedge clk);
            haddr = (t == 2) ? 32'hE000_0000 : 32'hF004_0000;
            htrans = t[1:0];
            step();
            chk_dp("R8", 32'd0, 1'b0, 1'b1);
            @(negedge clk);
            htrans = 2'd0; haddr = 32'h3000_0000;
            step();
            chk_dp("R8", 32'd0, 1'b1, 1'b1);
            step();
            chk_dp("R8", 32'hD000_0002, 1'b1, 1'b0);
        end

        // R10: plain routing, then a stalled data phase with moving address.
        @(negedge clk);
        haddr = 32'h9000_0000; htrans = 2'd2;
        step();
        chk_dp("R10", 32'hD000_0006, 1'b1, 1'b0);
        @(negedge clk);
        haddr = 32'h3000_0010; htrans = 2'd2;
        step();
        chk_dp("R10", 32'hD000_0002, 1'b1, 1'b0);
        @(negedge clk);
        t_hreadyout[2] = 1'b0;
        haddr = 32'h8000_0000;
        #1;
        chk_dp("R10", 32'hD000_0002, 1'b0, 1'b0);
        step();
        chk_dp("R10", 32'hD000_0002, 1'b0, 1'b0);
        @(negedge clk);
        t_hreadyout[2] = 1'b1;
        step();
        chk_dp("R10", 32'hD000_0005, 1'b1, 1'b0);

        // R11: remap flips while code RAM at zero is stalled.
        @(negedge clk);
        remap = 1'b1; haddr = 32'h0000_0100; htrans = 2'd2;
        step();
        chk_dp("R11", 32'hD000_0001, 1'b1, 1'b0);
        @(negedge clk);
        t_hreadyout[1] = 1'b0;
        remap = 1'b0;
        step();
        chk_dp("R11", 32'hD000_0001, 1'b0, 1'b0);
        @(negedge clk);
        t_hreadyout[1] = 1'b1;
        step();
        chk_dp("R11", 32'hD000_0000, 1'b1, 1'b0);
        chk("R11", hrdata_d, 32'hD000_0001);

        @(negedge clk);
        htrans = 2'd0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule